// File: doc/BRIEF.md
# Banked OTP fuse programming controller

This block programs a one-time-programmable fuse array arranged as banks of four 32-bit words. Software selects a bank and supplies a fixed unlock key in one write to the control register. It stages words in data registers 3, 2 and 1, then writes data register 0. Only that last write starts programming. The whole bank is burned in one operation. A staged word of zero leaves its fuse word untouched. The array is modelled as sticky bits: programming ORs the staged words into the stored words, so a bit that is set never clears.

The control register has a set alias and a clear alias. A timing register sets how many cycles a burn lasts. A busy flag is raised for that many cycles. While it is raised the register file accepts no writes. When a burn completes, the key field and the staged words are cleared, so every operation must be armed again. A start attempted with a wrong key, or with a bank number beyond the array, is refused and raises a sticky error flag. A separate read port returns any fuse word, so the array can be compared against a reference model.

Top module: `otp_bank_prog`

## Requirements
- R1: After reset, control reads 0, timing reads 4, the four data registers read 0 and every fuse word reads 0.
- R2: Register offsets: control 0x00, set alias 0x04, clear alias 0x08, timing 0x10 (bits 7:0 used), data j at 0x20 + 0x10*j for j = 0..3. Control fields: bank number in bits 6:0, busy in bit 8, error in bit 9, unlock key in bits 31:16. All other bits read 0.
- R3: A write to the set alias ORs the written bank and key bits into control. A write to the clear alias clears the written bank, key and error bits.
- R4: Writes to data registers 1 to 3 only stage their value and never start programming.
- R5: A write to data register 0 starts a burn when the key field holds 0x3E77 and the bank number is below the bank count. Busy rises on the next cycle and stays high for exactly max(T,1) cycles, where T is the timing value.
- R6: At the end of a burn, fuse word bank*4+j becomes its old value ORed with data register j, for j = 0..3. Fuse bits never clear.
- R7: While busy is high, every bus write is ignored, and the data registers and timing register keep their contents.
- R8: A write to data register 0 with a wrong key or an out-of-range bank starts nothing, does not stage the value and sets the error bit. The error bit stays set until it is cleared through the clear alias.
- R9: When a burn completes, the key field and all data registers become 0, and the bank field keeps its value.
- R10: The fuse read port returns, in the same cycle, the fuse word selected by its word index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| fuse_raddr | input | FUSE_AW | Fuse word index for the read port |
| fuse_rdata | output | DATA_W | Selected fuse word |

## Verification
The hardest case to reach is a register write that arrives during a burn. From the ports this needs a burn long enough to land several bus writes inside the busy window. The bench sets a long timing value, stages a known word in data register 1 and starts the burn. While busy is high it writes data 1, timing and control. It then reads data 1 and timing back before the burn ends. After completion it checks that the fuse word holds the value staged first, not the one written during the burn.

// File: rtl/otp_bank_pkg.sv
package otp_bank_pkg;
  localparam int OFS_CTRL      = 8'h00;
  localparam int OFS_SET       = 8'h04;
  localparam int OFS_CLR       = 8'h08;
  localparam int OFS_TIME      = 8'h10;
  localparam int OFS_DATA0     = 8'h20;
  localparam int OFS_DATA_STEP = 8'h10;
  localparam int BANK_W        = 7;
  localparam int POS_BUSY      = 8;
  localparam int POS_ERR       = 9;
  localparam int KEY_LSB       = 16;
  localparam int KEY_W         = 16;
endpackage

// File: rtl/otp_prog_seq.sv
module otp_prog_seq #(
  parameter int TIME_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [TIME_W-1:0] cycles,
  output logic              busy,
  output logic              done
);
  logic [TIME_W-1:0] cnt_q, cnt_d;
  logic              busy_q, busy_d;
  logic              seq_en;

  assign done   = busy_q && (cnt_q == TIME_W'(1));
  assign busy   = busy_q;
  assign seq_en = start | busy_q;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (start) begin
      cnt_d  = (cycles == '0) ? TIME_W'(1) : cycles;
      busy_d = 1'b1;
    end else if (busy_q) begin
      cnt_d  = cnt_q - TIME_W'(1);
      busy_d = ~done;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (seq_en) begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end
endmodule

// File: rtl/otp_fuse_array.sv
module otp_fuse_array #(
  parameter int NUM_BANKS = 16,
  parameter int WORDS     = 4,
  parameter int DATA_W    = 32,
  parameter int BANK_W    = 7,
  parameter int FUSE_AW   = $clog2(NUM_BANKS*WORDS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    burn,
  input  logic [BANK_W-1:0]       bank,
  input  logic [WORDS*DATA_W-1:0] burn_data,
  input  logic [FUSE_AW-1:0]      raddr,
  output logic [DATA_W-1:0]       rdata
);
  localparam int DEPTH = NUM_BANKS * WORDS;

  logic [DATA_W-1:0] fuse_q [DEPTH];

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    localparam int WB = w / WORDS;
    localparam int WJ = w % WORDS;
    logic word_en;
    assign word_en = burn && (bank == BANK_W'(WB));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fuse_q[w] <= '0;
      end else if (word_en) begin
        fuse_q[w] <= fuse_q[w] | burn_data[WJ*DATA_W +: DATA_W];
      end
    end
  end

  assign rdata = (32'(raddr) < 32'(DEPTH)) ? fuse_q[raddr] : '0;
endmodule

// File: rtl/otp_bank_prog.sv
module otp_bank_prog
  import otp_bank_pkg::*;
#(
  parameter int              NUM_BANKS  = 16,
  parameter int              WORDS      = 4,
  parameter int              DATA_W     = 32,
  parameter int              TIME_W     = 8,
  parameter int              TIME_RESET = 4,
  parameter logic [KEY_W-1:0] UNLOCK_KEY = 16'h3E77,
  parameter int              FUSE_AW    = $clog2(NUM_BANKS*WORDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [7:0]         bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [FUSE_AW-1:0] fuse_raddr,
  output logic [DATA_W-1:0]  fuse_rdata
);
  localparam int STAGE_W = WORDS * DATA_W;

  // reset synchroniser: asynchronous assert, synchronous release
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic [BANK_W-1:0]  bank_q, bank_d;
  logic [KEY_W-1:0]   key_q, key_d;
  logic               err_q, err_d;
  logic [TIME_W-1:0]  time_q, time_d;
  logic [STAGE_W-1:0] stage_q, stage_d;
  logic               prog_busy, prog_done;
  logic               wr_ok, key_ok, bank_ok, start, reject, upd_en;
  logic               hit_ctrl, hit_set, hit_clr, hit_time;
  logic [WORDS-1:0]   hit_data;
  logic [DATA_W-1:0]  ctrl_rd;

  assign hit_ctrl = (bus_addr == 8'(OFS_CTRL));
  assign hit_set  = (bus_addr == 8'(OFS_SET));
  assign hit_clr  = (bus_addr == 8'(OFS_CLR));
  assign hit_time = (bus_addr == 8'(OFS_TIME));
  for (genvar j = 0; j < WORDS; j++) begin : g_dec
    assign hit_data[j] = (bus_addr == 8'(OFS_DATA0 + OFS_DATA_STEP*j));
  end

  assign wr_ok   = bus_wr & ~prog_busy;
  assign key_ok  = (key_q == UNLOCK_KEY);
  assign bank_ok = (32'(bank_q) < 32'(NUM_BANKS));
  assign start   = wr_ok & hit_data[0] & key_ok & bank_ok;
  assign reject  = wr_ok & hit_data[0] & ~(key_ok & bank_ok);
  assign upd_en  = wr_ok | prog_done;

  always_comb begin
    bank_d  = bank_q;
    key_d   = key_q;
    err_d   = err_q;
    time_d  = time_q;
    stage_d = stage_q;
    if (wr_ok) begin
      if (hit_ctrl) begin
        bank_d = bus_wdata[BANK_W-1:0];
        key_d  = bus_wdata[KEY_LSB +: KEY_W];
      end
      if (hit_set) begin
        bank_d = bank_q | bus_wdata[BANK_W-1:0];
        key_d  = key_q | bus_wdata[KEY_LSB +: KEY_W];
      end
      if (hit_clr) begin
        bank_d = bank_q & ~bus_wdata[BANK_W-1:0];
        key_d  = key_q & ~bus_wdata[KEY_LSB +: KEY_W];
        err_d  = err_q & ~bus_wdata[POS_ERR];
      end
      if (hit_time) time_d = bus_wdata[TIME_W-1:0];
      for (int j = 1; j < WORDS; j++) begin
        if (hit_data[j]) stage_d[j*DATA_W +: DATA_W] = bus_wdata;
      end
      if (start) stage_d[DATA_W-1:0] = bus_wdata;
    end
    if (reject) err_d = 1'b1;
    if (prog_done) begin
      key_d   = '0;
      stage_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      bank_q  <= '0;
      key_q   <= '0;
      err_q   <= 1'b0;
      time_q  <= TIME_W'(TIME_RESET);
      stage_q <= '0;
    end else if (upd_en) begin
      bank_q  <= bank_d;
      key_q   <= key_d;
      err_q   <= err_d;
      time_q  <= time_d;
      stage_q <= stage_d;
    end
  end

  otp_prog_seq #(.TIME_W(TIME_W)) u_seq (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .start  (start),
    .cycles (time_q),
    .busy   (prog_busy),
    .done   (prog_done)
  );

  otp_fuse_array #(
    .NUM_BANKS (NUM_BANKS),
    .WORDS     (WORDS),
    .DATA_W    (DATA_W),
    .BANK_W    (BANK_W),
    .FUSE_AW   (FUSE_AW)
  ) u_fuse (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .burn      (prog_done),
    .bank      (bank_q),
    .burn_data (stage_q),
    .raddr     (fuse_raddr),
    .rdata     (fuse_rdata)
  );

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[BANK_W-1:0]          = bank_q;
    ctrl_rd[POS_BUSY]            = prog_busy;
    ctrl_rd[POS_ERR]             = err_q;
    ctrl_rd[KEY_LSB +: KEY_W]    = key_q;
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_ctrl || hit_set || hit_clr) bus_rdata = ctrl_rd;
    if (hit_time) bus_rdata = DATA_W'(time_q);
    for (int j = 0; j < WORDS; j++) begin
      if (hit_data[j]) bus_rdata = stage_q[j*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/otp_bank_prog_chk.sv
module otp_bank_prog_chk #(
  parameter int               WORDS      = 4,
  parameter int               DATA_W     = 32,
  parameter int               FUSE_AW    = 6,
  parameter logic [15:0]      UNLOCK_KEY = 16'h3E77
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    bus_wr,
  input logic [7:0]              bus_addr,
  input logic [FUSE_AW-1:0]      fuse_raddr,
  input logic [DATA_W-1:0]       fuse_rdata,
  input logic                    busy,
  input logic                    done,
  input logic [15:0]             key,
  input logic                    err,
  input logic [WORDS*DATA_W-1:0] stage
);
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);  // R5

  AST_STAGE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(stage));  // R7

  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && key == '0 && stage == '0));  // R9

  AST_FUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (!$stable(fuse_raddr) || (($past(fuse_rdata) & ~fuse_rdata) == '0)));  // R6

  AST_REJECT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h20 && !busy && key != UNLOCK_KEY) |=> (err && !busy));  // R8
endmodule

bind otp_bank_prog otp_bank_prog_chk #(
  .WORDS      (WORDS),
  .DATA_W     (DATA_W),
  .FUSE_AW    (FUSE_AW),
  .UNLOCK_KEY (UNLOCK_KEY)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .fuse_raddr (fuse_raddr),
  .fuse_rdata (fuse_rdata),
  .busy       (prog_busy),
  .done       (prog_done),
  .key        (key_q),
  .err        (err_q),
  .stage      (stage_q)
);

// File: tb/otp_bank_prog_bench.sv
`timescale 1ns/1ps
module otp_bank_prog_bench;
  localparam int NV = 8;
  localparam logic [5:0]  VEC_WORD [NV] = '{6'd0, 6'd5, 6'd10, 6'd15, 6'd0, 6'd63, 6'd5, 6'd62};
  localparam logic [31:0] VEC_VAL  [NV] = '{32'h0000_00A5, 32'h1234_5678, 32'hFFFF_0000,
                                            32'h8000_0001, 32'h0000_5A00, 32'hDEAD_BEEF,
                                            32'h0000_0000, 32'h0F0F_0F0F};
  localparam logic [31:0] KEYW = 32'h3E77_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [5:0]  fuse_raddr = '0;
  logic [31:0] fuse_rdata;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [31:0] model [64];

  always #2 clk = ~clk;

  otp_bank_prog u_otp_bank_prog (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fuse_raddr(fuse_raddr), .fuse_rdata(fuse_rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic fuse(input logic [5:0] k, output logic [31:0] d);
    @(negedge clk);
    fuse_raddr = k;
    #1 d = fuse_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] c;
    bit idle = 1'b0;
    for (int i = 0; i < 300 && !idle; i++) begin
      rd(8'h00, c);
      if (!c[8]) idle = 1'b1;
    end
    if (!idle) check("R5 busy never cleared", 32'd1, 32'd0);
  endtask

  task automatic program_word(input logic [5:0] k, input logic [31:0] v);
    logic [31:0] d;
    wr(8'h00, KEYW | 32'(k[5:2]));
    for (int j = 3; j >= 1; j--)
      wr(8'(8'h20 + 16*j), (k[1:0] == 2'(j)) ? v : 32'h0);
    wr(8'h20, (k[1:0] == 2'd0) ? v : 32'h0);
    wait_idle();
    model[k] = model[k] | v;
    for (int j = 0; j < 4; j++) begin
      fuse({k[5:2], 2'(j)}, d);
      check("R6 R10 bank word after burn", d, model[{k[5:2], 2'(j)}]);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog all requirements actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int n;
    for (int i = 0; i < 64; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(8'h00, d); check("R1 ctrl reset", d, 32'h0);
    rd(8'h10, d); check("R1 timing reset", d, 32'd4);
    for (int j = 0; j < 4; j++) begin
      rd(8'(8'h20 + 16*j), d); check("R1 data reset", d, 32'h0);
    end
    fuse(6'd0, d);  check("R1 fuse 0 reset", d, 32'h0);
    fuse(6'd63, d); check("R1 fuse 63 reset", d, 32'h0);

    // table of bank programming vectors (R6 R10, OR-accumulation, zero word)
    for (int v = 0; v < NV; v++) program_word(VEC_WORD[v], VEC_VAL[v]);

    // R5 busy duration for T=6 and T=0
    wr(8'h10, 32'd6);
    wr(8'h00, KEYW | 32'd4);
    wr(8'h20, 32'h0);
    n = 0;
    bus_addr = 8'h00; #1;
    while (bus_rdata[8] && n < 100) begin
      n++; @(negedge clk); #1;
    end
    check("R5 busy cycles T=6", 32'(n), 32'd6);
    wr(8'h10, 32'd0);
    wr(8'h00, KEYW | 32'd4);
    wr(8'h20, 32'h0);
    n = 0;
    bus_addr = 8'h00; #1;
    while (bus_rdata[8] && n < 100) begin
      n++; @(negedge clk); #1;
    end
    check("R5 busy cycles T=0", 32'(n), 32'd1);

    // R7 writes during a burn are ignored
    wr(8'h10, 32'd40);
    wr(8'h00, KEYW | 32'd5);
    wr(8'h30, 32'h0000_0055);
    wr(8'h20, 32'h0);
    wr(8'h30, 32'h0000_00AA);
    wr(8'h10, 32'd3);
    wr(8'h00, 32'h0);
    rd(8'h30, d); check("R7 data1 kept during burn", d, 32'h0000_0055);
    rd(8'h10, d); check("R7 timing kept during burn", d, 32'd40);
    rd(8'h00, d); check("R5 busy flag during burn", {31'b0, d[8]}, 32'd1);
    wait_idle();
    model[21] = model[21] | 32'h55;
    fuse(6'd21, d); check("R7 fuse holds first staged word", d, 32'h0000_0055);
    rd(8'h30, d); check("R9 data1 cleared after burn", d, 32'h0);
    rd(8'h00, d); check("R9 key cleared bank kept", d, 32'h0000_0005);
    wr(8'h10, 32'd4);

    // R8 wrong key
    wr(8'h00, 32'h0000_0006);
    wr(8'h20, 32'h0000_FFFF);
    rd(8'h00, d); check("R8 error set no busy", d, 32'h0000_0206);
    rd(8'h20, d); check("R8 data0 not staged", d, 32'h0);
    fuse(6'd24, d); check("R8 fuse untouched", d, 32'h0);
    wr(8'h08, 32'h0000_0200);
    rd(8'h00, d); check("R8 R3 error cleared by clear alias", d, 32'h0000_0006);

    // R8 bank out of range
    wr(8'h00, KEYW | 32'd20);
    wr(8'h20, 32'h1);
    rd(8'h00, d); check("R8 bank out of range", d, 32'h3E77_0214);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h00, d); check("R3 clear alias all", d, 32'h0);

    // R3 set and clear aliases
    wr(8'h00, 32'd3);
    wr(8'h04, 32'd4);
    rd(8'h00, d); check("R3 set alias bank", d, 32'd7);
    wr(8'h08, 32'd1);
    rd(8'h00, d); check("R3 clear alias bank", d, 32'd6);
    wr(8'h04, KEYW);
    rd(8'h04, d); check("R2 R3 set alias key, read via alias", d, 32'h3E77_0006);

    // R4 staging registers never start a burn
    wr(8'h40, 32'h0000_0077);
    repeat (5) @(negedge clk);
    rd(8'h00, d); check("R4 no busy after data2 write", {31'b0, d[8]}, 32'd0);
    fuse(6'd26, d); check("R4 fuse untouched", d, 32'h0);
    rd(8'h40, d); check("R2 data2 readback", d, 32'h0000_0077);
    wr(8'h50, 32'h0000_0099);
    rd(8'h50, d); check("R2 R4 data3 readback", d, 32'h0000_0099);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule